// File: doc/BRIEF.md
# Multi-Width Packed Adder with Operand Isolation

This block adds two 32-bit words either as four independent bytes, as two independent halfwords, or as one full word. A two-bit mode input chooses the packing on each request. Byte and halfword work runs on a cluster of four small ripple-carry byte adders. The cluster chains neighbouring pairs together for halfword work. Full-word work runs on a separate word adder.

Each adder group sits behind its own bank of operand registers. A bank loads only when a valid request selects that group. The group that is not in use keeps its inputs frozen, so none of its internal nodes toggle. The result is registered with a per-lane carry vector and an output strobe. It appears on the second rising clock edge after the request is accepted.

Top module: `simd_energy_adder`

## Requirements
- R1: Mode 2'b00 performs four independent 8-bit additions: sum byte i is (a byte i + b byte i) mod 256, and no carry moves between bytes. out_carry[i] is the carry out of byte i.
- R2: Mode 2'b01 performs two independent 16-bit additions: the carry out of bit 7 reaches bit 8 and the carry out of bit 23 reaches bit 24, but no carry crosses from bit 15 to bit 16. out_carry[1] is the carry of the low halfword and out_carry[3] the carry of the high halfword, and out_carry[0] and out_carry[2] are 0.
- R3: Mode 2'b10 performs one 32-bit addition. out_carry[3] is its carry out, and out_carry[2:0] are 0.
- R4: A request is accepted when in_valid is 1 and the mode is not 2'b11. Its result and out_valid appear after the second rising edge following acceptance. out_valid is high for exactly one cycle for each accepted request, and requests may follow back to back.
- R5: In a cycle with no accepted request in the first stage, out_valid is 0 and out_sum and out_carry keep their previous values.
- R6: Mode 2'b11 is reserved. A request carrying it is not accepted and leaves out_valid low and the outputs unchanged.
- R7: The operand registers of the word adder change only on an accepted 2'b10 request. The operand registers of the byte cluster change only on an accepted 2'b00 or 2'b01 request. Interleaving the modes therefore never disturbs either result.
- R8: While rst_n is low, and after it is released, out_valid, out_sum and out_carry are 0 until the first result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Packing: 00 bytes, 01 halfwords, 10 word, 11 reserved |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result strobe |
| out_sum | output | 32 | Registered packed sum |
| out_carry | output | 4 | Per-lane carry out, mapped per mode |

## Verification
The assertions assume a clean reset. They also assume that in_mode and the operands are sampled only in cycles where in_valid is high, so any value is legal when in_valid is low. The stimulus relies on this: between requests it drives junk operands and the reserved mode, both with and without the strobe. Carry-edge vectors such as all-ones plus one are chosen so that any leak across a lane boundary shows up in the sum. A long pseudo-random run then mixes the three modes with idle and reserved cycles, so the isolation banks hold for stretches of different lengths.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE = 2'b00,
        MODE_HALF = 2'b01,
        MODE_WORD = 2'b10,
        MODE_RSVD = 2'b11
    } add_mode_e;

    function automatic logic mode_is_narrow(add_mode_e m);
        return (m == MODE_BYTE) || (m == MODE_HALF);
    endfunction

endpackage

// File: rtl/lane_ripple_add.sv
module lane_ripple_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    assign cout = chain[W];
endmodule

// File: rtl/narrow_cluster.sv
module narrow_cluster #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [LANE_W*LANES-1:0] a,
    input  logic [LANE_W*LANES-1:0] b,
    input  logic                    pair_en,
    output logic [LANE_W*LANES-1:0] sum,
    output logic [LANES-1:0]        lane_co
);
    logic [LANES-1:0] lane_ci;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if ((l % 2) == 1) begin : g_odd
            // odd lanes take the carry of their even neighbour when paired
            assign lane_ci[l] = pair_en & lane_co[l-1];
        end else begin : g_even
            assign lane_ci[l] = 1'b0;
        end

        lane_ripple_add #(.W(LANE_W)) u_lane (
            .a    (a[l*LANE_W +: LANE_W]),
            .b    (b[l*LANE_W +: LANE_W]),
            .cin  (lane_ci[l]),
            .sum  (sum[l*LANE_W +: LANE_W]),
            .cout (lane_co[l])
        );
    end
endmodule

// File: rtl/wide_add.sv
module wide_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;

    assign full = {1'b0, a} + {1'b0, b};
    assign sum  = full[W-1:0];
    assign cout = full[W];
endmodule

// File: rtl/simd_energy_adder.sv
module simd_energy_adder
    import simd_add_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_mode,
    input  logic [LANE_W*LANES-1:0] in_a,
    input  logic [LANE_W*LANES-1:0] in_b,
    output logic                    out_valid,
    output logic [LANE_W*LANES-1:0] out_sum,
    output logic [LANES-1:0]        out_carry
);
    localparam int WORD_W = LANE_W * LANES;

    typedef struct packed {
        logic [WORD_W-1:0] nar_a;
        logic [WORD_W-1:0] nar_b;
        logic              nar_pair;
        logic [WORD_W-1:0] wid_a;
        logic [WORD_W-1:0] wid_b;
        logic              stg_vld;
        add_mode_e         stg_mode;
        logic              res_vld;
        logic [WORD_W-1:0] res_sum;
        logic [LANES-1:0]  res_carry;
    } state_t;

    state_t st_q, st_d;

    add_mode_e         mode_in;
    logic              accept;
    logic [WORD_W-1:0] nar_sum;
    logic [LANES-1:0]  nar_co;
    logic [WORD_W-1:0] wid_sum;
    logic              wid_co;

    assign mode_in = add_mode_e'(in_mode);
    assign accept  = in_valid && (mode_in != MODE_RSVD);

    narrow_cluster #(.LANE_W(LANE_W), .LANES(LANES)) u_narrow (
        .a       (st_q.nar_a),
        .b       (st_q.nar_b),
        .pair_en (st_q.nar_pair),
        .sum     (nar_sum),
        .lane_co (nar_co)
    );

    wide_add #(.W(WORD_W)) u_wide (
        .a    (st_q.wid_a),
        .b    (st_q.wid_b),
        .sum  (wid_sum),
        .cout (wid_co)
    );

    always_comb begin
        st_d = st_q;

        // operand isolation: only the selected group loads
        if (in_valid && mode_is_narrow(mode_in)) begin
            st_d.nar_a    = in_a;
            st_d.nar_b    = in_b;
            st_d.nar_pair = (mode_in == MODE_HALF);
        end
        if (in_valid && (mode_in == MODE_WORD)) begin
            st_d.wid_a = in_a;
            st_d.wid_b = in_b;
        end

        st_d.stg_vld = accept;
        if (accept) begin
            st_d.stg_mode = mode_in;
        end

        st_d.res_vld = st_q.stg_vld;
        if (st_q.stg_vld) begin
            if (st_q.stg_mode == MODE_WORD) begin
                st_d.res_sum              = wid_sum;
                st_d.res_carry            = '0;
                st_d.res_carry[LANES-1]   = wid_co;
            end else begin
                st_d.res_sum = nar_sum;
                for (int l = 0; l < LANES; l++) begin
                    st_d.res_carry[l] = ((st_q.stg_mode == MODE_HALF) && ((l % 2) == 0))
                                        ? 1'b0 : nar_co[l];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.stg_mode <= MODE_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.res_vld;
    assign out_sum   = st_q.res_sum;
    assign out_carry = st_q.res_carry;

    // R7: word operands frozen unless a word request arrives
    p_wide_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_mode == 2'b10) |=> $stable(st_q.wid_a) && $stable(st_q.wid_b));

    // R7: byte-cluster operands frozen unless a narrow request arrives
    p_narrow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (in_mode == 2'b00 || in_mode == 2'b01))
        |=> $stable(st_q.nar_a) && $stable(st_q.nar_b) && $stable(st_q.nar_pair));

    // R4: a staged request always produces a strobe on the next edge
    p_strobe_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stg_vld |=> out_valid);

    // R5: without a staged request, outputs hold and the strobe stays low
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stg_vld |=> !out_valid && $stable(out_sum) && $stable(out_carry));

    // R6: a reserved request never enters the pipeline
    p_reserved_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b11) |=> !st_q.stg_vld);

    // R2: even-lane carry flags are cleared for halfword results
    p_half_carry_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg_vld && st_q.stg_mode == MODE_HALF) |=> (out_carry[0] == 1'b0) && (out_carry[2] == 1'b0));

    // R3: only the top carry flag may be set for word results
    p_word_carry_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg_vld && st_q.stg_mode == MODE_WORD) |=> $countones(out_carry[LANES-2:0]) == 0);
endmodule

// File: tb/simd_energy_adder_bench.sv
module simd_energy_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_sum;
    logic [3:0]  out_carry;

    int checks = 0;
    int errors = 0;

    // reference pipeline: stage then output
    bit          st_v = 0;
    logic [31:0] st_sum = '0;
    logic [3:0]  st_car = '0;
    string       st_tag = "R5";
    bit          ex_v = 0;
    logic [31:0] ex_sum = '0;
    logic [3:0]  ex_car = '0;
    string       ex_tag = "R8";

    always #2.5 clk = ~clk;

    simd_energy_adder u_simd_energy_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_sum(out_sum), .out_carry(out_carry)
    );

    task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic ref_add(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] s, output logic [3:0] c);
        s = '0; c = '0;
        if (m == 2'b00) begin
            for (int l = 0; l < 4; l++) begin
                logic [8:0] t;
                t = {1'b0, a[l*8 +: 8]} + {1'b0, b[l*8 +: 8]};
                s[l*8 +: 8] = t[7:0];
                c[l] = t[8];
            end
        end else if (m == 2'b01) begin
            for (int h = 0; h < 2; h++) begin
                logic [16:0] t;
                t = {1'b0, a[h*16 +: 16]} + {1'b0, b[h*16 +: 16]};
                s[h*16 +: 16] = t[15:0];
                c[h*2+1] = t[16];
            end
        end else begin
            logic [32:0] t;
            t = {1'b0, a} + {1'b0, b};
            s = t[31:0];
            c[3] = t[32];
        end
    endtask

    // one cycle: compare what the last edge produced, then advance the model and drive
    task automatic step(bit v, logic [1:0] m, logic [31:0] a, logic [31:0] b, string tag);
        @(negedge clk);
        check32("R4", "out_valid", {31'b0, out_valid}, {31'b0, ex_v});
        check32(ex_tag, "out_sum", out_sum, ex_sum);
        check32(ex_tag, "out_carry", {28'b0, out_carry}, {28'b0, ex_car});
        ex_v = st_v;
        if (st_v) begin
            ex_sum = st_sum; ex_car = st_car; ex_tag = st_tag;
        end else begin
            ex_tag = st_tag;
        end
        st_v = v && (m != 2'b11);
        if (st_v) begin
            ref_add(m, a, b, st_sum, st_car);
            st_tag = tag;
        end else begin
            st_tag = (v && m == 2'b11) ? "R6" : "R5";
        end
        in_valid = v; in_mode = m; in_a = a; in_b = b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'(i), 32'hDEAD_0000 + 32'(i), 32'h0BAD_F00D, "R5");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        in_valid = 1'b1; in_mode = 2'b10; in_a = 32'hFFFF_FFFF; in_b = 32'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check32("R8", "out_valid in reset", {31'b0, out_valid}, 32'h0);
        check32("R8", "out_sum in reset", out_sum, 32'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R1: each byte wraps on its own, carries flagged per lane
        step(1'b1, 2'b00, 32'hFF80_7FFF, 32'h0180_0101, "R1");
        step(1'b1, 2'b00, 32'h1234_5678, 32'h1111_1111, "R1");
        // R2: carry crosses bit 7 and bit 23 but not bit 15
        step(1'b1, 2'b01, 32'h00FF_FFFF, 32'h0001_0001, "R2");
        step(1'b1, 2'b01, 32'hFFFF_00FF, 32'h0001_0001, "R2");
        // R3: full-word carry ripples to the top
        step(1'b1, 2'b10, 32'hFFFF_FFFF, 32'h0000_0001, "R3");
        step(1'b1, 2'b10, 32'h7FFF_FFFF, 32'h0000_0001, "R3");
        idle(3);
        // R6: reserved request ignored, outputs hold
        step(1'b1, 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
        step(1'b1, 2'b11, 32'h1234_5678, 32'h8765_4321, "R6");
        idle(2);
        // R7: interleave groups; each bank must keep its own operands
        step(1'b1, 2'b10, 32'h8000_0000, 32'h8000_0000, "R7");
        step(1'b1, 2'b00, 32'h0101_0101, 32'hFFFF_FFFF, "R7");
        step(1'b0, 2'b10, 32'h5555_5555, 32'h5555_5555, "R7");
        step(1'b1, 2'b01, 32'h8000_8000, 32'h8000_8000, "R7");
        step(1'b1, 2'b10, 32'hA5A5_A5A5, 32'h5A5A_5A5A, "R7");
        idle(2);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            bit v;
            m = 2'($urandom_range(0, 3));
            v = ($urandom_range(0, 3) != 0);
            step(v, m, $urandom, $urandom, (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : "R3");
        end
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule